// File: doc/BRIEF.md
# Packed Word Minimum-and-Index Finder

This block takes a 128-bit operand made of eight unsigned 16-bit word lanes and finds the smallest word together with the lane that holds it. Lane k sits in bits 16k+15:16k of the operand. The answer comes back as a 128-bit result. The minimum value is in the lowest word and the lane number is in the word above it. Every other bit of the result is zero.

The search runs as a three-level pairwise comparison tree. Each node passes on a value and a lane index. When two values are equal, the node keeps the lower-numbered lane, so on a tie the smallest index wins. The result and its valid flag are registered, so the answer appears one clock after the operand is accepted. While no operand is presented, the result register keeps its last contents.

Top module: `word_min_finder`

## Requirements
- R1: After a clock edge with rst_n low, res_vld is 0 and res_data is all zeros.
- R2: res_vld equals the value that op_vld had at the previous clock edge, so the latency is exactly one cycle.
- R3: When op_vld is high, res_data[15:0] becomes the smallest of the eight lanes of op_data, compared as unsigned 16-bit numbers, one cycle later.
- R4: res_data[18:16] holds the number (0 to 7) of a lane whose value equals the reported minimum.
- R5: When several lanes share the minimum value, the reported index is the lowest-numbered of those lanes.
- R6: res_data[31:19] and res_data[127:32] are always zero.
- R7: When op_vld is low, res_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_vld | input | 1 | The operand is valid this cycle |
| op_data | input | 128 | Eight unsigned 16-bit lanes; lane k is in bits 16k+15:16k |
| res_vld | output | 1 | The result is valid |
| res_data | output | 128 | Bits 15:0 hold the minimum, bits 18:16 hold the lane index, all other bits are zero |

## Verification
Every result, including its valid flag, is due exactly one clock edge after the operand is driven. The bench drives op_data and op_vld on the falling edge. It samples the outputs on the next falling edge, which is one rising edge later, and compares them with a minimum and index computed by a plain linear scan. To check that the result holds when op_vld is low, the bench drives a new operand with op_vld low and confirms one cycle later that res_data still has its previous value.

// File: rtl/wmin_pkg.sv
// Package wmin_pkg
// Purpose: the lane geometry and the node record shared by the min-finder modules.
// Assumes: the lane count is a power of two.
package wmin_pkg;
    localparam int unsigned LANE_W   = 16;
    localparam int unsigned LANES    = 8;
    localparam int unsigned IDX_W    = $clog2(LANES);
    localparam int unsigned VEC_W    = LANE_W * LANES;
    localparam int unsigned LEVELS   = $clog2(LANES);

    typedef struct packed {
        logic [LANE_W-1:0] val;
        logic [IDX_W-1:0]  idx;
    } node_t;
endpackage

// File: rtl/wmin_node.sv
// Module wmin_node
// Purpose: one comparison node. It passes on the smaller of two candidates.
// Assumes: the left input always comes from lower-numbered lanes than the right input,
// so choosing the left input on a tie gives the lowest lane index.
module wmin_node
    import wmin_pkg::*;
(
    input  node_t lft,
    input  node_t rgt,
    output node_t win
);
    // Pick the right input only when it is strictly smaller.
    always_comb begin
        if (rgt.val < lft.val) win = rgt;
        else                   win = lft;
    end
endmodule

// File: rtl/wmin_tree.sv
// Module wmin_tree
// Purpose: a combinational pairwise reduction over every lane, giving the minimum and its index.
// Assumes: NL is a power of two; level 0 holds the lanes in ascending order.
module wmin_tree
    import wmin_pkg::*;
#(
    parameter int unsigned NL = LANES
) (
    input  logic [NL*LANE_W-1:0] vec,
    output node_t                best
);
    localparam int unsigned NLEV = $clog2(NL);

    // The levels are laid out flat: level l begins at offset 2*NL - (NL >> (l-1)).
    node_t nodes [2*NL-1];

    genvar g, lv;
    generate
        for (g = 0; g < NL; g++) begin : g_leaf
            // Turn each lane into a leaf node tagged with its lane number.
            always_comb begin
                nodes[g].val = vec[g*LANE_W +: LANE_W];
                nodes[g].idx = IDX_W'(g);
            end
        end
        for (lv = 1; lv <= NLEV; lv++) begin : g_lvl
            localparam int unsigned CNT  = NL >> lv;
            localparam int unsigned SRC  = 2*NL - (NL >> (lv-1)) * 2;
            localparam int unsigned DST  = 2*NL - (NL >> (lv-1));
            for (g = 0; g < CNT; g++) begin : g_cmp
                wmin_node u_node (
                    .lft (nodes[SRC + 2*g]),
                    .rgt (nodes[SRC + 2*g + 1]),
                    .win (nodes[DST + g])
                );
            end
        end
    endgenerate

    assign best = nodes[2*NL-2];
endmodule

// File: rtl/word_min_finder.sv
// Module word_min_finder
// Purpose: finds the unsigned minimum of the 16-bit lanes and its index, packed into a
// 128-bit result that is registered with one cycle of latency.
// Assumes: rst_n is synchronous and active low; the result holds while op_vld is low.
module word_min_finder
    import wmin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_vld,
    input  logic [VEC_W-1:0] op_data,
    output logic             res_vld,
    output logic [VEC_W-1:0] res_data
);
    node_t            best;
    logic [VEC_W-1:0] packed_res;

    wmin_tree #(.NL(LANES)) u_tree (
        .vec  (op_data),
        .best (best)
    );

    // Put the value in word 0 and the index in word 1; all other bits are zero.
    always_comb begin
        packed_res = '0;
        packed_res[LANE_W-1:0]             = best.val;
        packed_res[LANE_W +: IDX_W]        = best.idx;
    end

    // The valid flag follows op_vld by exactly one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) res_vld <= 1'b0;
        else        res_vld <= op_vld;
    end

    // Capture a new result when op_vld is high; otherwise hold the old one.
    always_ff @(posedge clk) begin
        if (!rst_n)      res_data <= '0;
        else if (op_vld) res_data <= packed_res;
    end
endmodule

// File: rtl/word_min_finder_chk.sv
// Module word_min_finder_chk
// Purpose: the protocol and field checks for word_min_finder, attached with bind.
// Assumes: it is sampled on the same clock and synchronous reset as the design.
module word_min_finder_chk
    import wmin_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             op_vld,
    input logic [VEC_W-1:0] op_data,
    input logic             res_vld,
    input logic [VEC_W-1:0] res_data
);
    // R2: the valid flag has a latency of exactly one cycle.
    p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_vld == $past(op_vld)));

    // R6: the unused bits stay zero.
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_data[VEC_W-1:LANE_W+IDX_W] == '0);

    // R7: the result holds while op_vld is low.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(op_vld)) |-> $stable(res_data));

    // R4: the reported lane holds the reported value.
    p_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_vld)) |->
        ($past(op_data) >> (LANE_W * res_data[LANE_W +: IDX_W])) % (1 << LANE_W)
            == VEC_W'(res_data[LANE_W-1:0]));

    // R1: after a reset edge, the outputs are cleared.
    p_rst_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!res_vld && res_data == '0));
endmodule

bind word_min_finder word_min_finder_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_vld   (op_vld),
    .op_data  (op_data),
    .res_vld  (res_vld),
    .res_data (res_data)
);

// File: tb/test_word_min_finder.sv
module test_word_min_finder;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         op_vld;
    logic [127:0] op_data;
    logic         res_vld;
    logic [127:0] res_data;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    word_min_finder i_word_min_finder (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_data(op_data),
        .res_vld(res_vld), .res_data(res_data)
    );

    // The expected packed result, computed by a linear scan that keeps the first minimum.
    function automatic logic [127:0] model(input logic [127:0] v);
        logic [15:0] m;
        int          k;
        m = v[15:0];
        k = 0;
        for (int i = 1; i < 8; i++)
            if (v[i*16 +: 16] < m) begin m = v[i*16 +: 16]; k = i; end
        model = '0;
        model[15:0]  = m;
        model[18:16] = 3'(k);
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Drive one operand on the falling edge and check one rising edge later.
    task automatic apply(input logic [127:0] v, input string req);
        op_data = v; op_vld = 1'b1;
        @(negedge clk);
        check(req, res_data, model(v));
        check("R2", {127'd0, res_vld}, 128'd1);
    endtask

    initial begin
        logic [127:0] v;
        logic [127:0] prev;
        rst_n = 1'b0; op_vld = 1'b0; op_data = '1;
        @(negedge clk); @(negedge clk);
        check("R1", {127'd0, res_vld}, 128'd0);
        check("R1", res_data, 128'd0);
        rst_n = 1'b1;

        // R3 and R4: a single distinct minimum placed in each lane in turn.
        for (int p = 0; p < 8; p++) begin
            v = {8{16'hFFFF}};
            v[p*16 +: 16] = 16'(100 + p);
            apply(v, "R3/R4");
        end
        // R5: ties over every subset of lanes (all 255 non-empty masks).
        for (int m = 1; m < 256; m++) begin
            for (int i = 0; i < 8; i++) v[i*16 +: 16] = m[i] ? 16'h0042 : 16'h8000 + 16'(i);
            apply(v, "R5");
        end
        // R5: all lanes equal at the extreme values.
        apply('0, "R5");
        apply('1, "R5");
        // R3 and R6: unsigned order, where large values must not be read as negative.
        apply({16'h7FFF, 16'h8000, 16'hFFFE, 16'h9000, 16'hA000, 16'hB000, 16'hC000, 16'hF000}, "R3/R6");
        // R3: pseudo-random operands.
        for (int n = 0; n < 3000; n++) begin
            v = {$urandom, $urandom, $urandom, $urandom};
            if (n % 3 == 0) v[(n%8)*16 +: 16] = v[((n+3)%8)*16 +: 16];
            apply(v, "R3");
        end
        // R7 and R2: with op_vld low, the result holds and res_vld drops.
        prev = res_data;
        op_vld = 1'b0; op_data = 128'h1;
        @(negedge clk);
        check("R7", res_data, prev);
        check("R2", {127'd0, res_vld}, 128'd0);
        @(negedge clk);
        check("R7", res_data, prev);
        // R1: reset in the middle of a run.
        op_vld = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R1", res_data, 128'd0);
        check("R1", {127'd0, res_vld}, 128'd0);
        rst_n = 1'b1; op_vld = 1'b0;
        done = 1'b1;
    end

    // End the run: either normally, or when the watchdog expires, which counts as a failure.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog act=timeout exp=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule